// File: doc/BRIEF.md
# Four-Bit Function-Select Arithmetic/Logic Slice

This block is a purely combinational four-bit arithmetic and logic slice. A four-bit select code picks one of sixteen functions. A mode input chooses between the bitwise logic set and the arithmetic set. Both sets decode the same select code.

Every arithmetic function comes from a single adder path. Two per-bit operand terms are formed from A, B and the select code, then added together with the carry. The slice also exports an active-low group generate and an active-low group propagate, so an external lookahead unit can combine several slices. It flags a result of all ones, which serves as an equality test when the slice subtracts. The carry input and the carry output both use inverted polarity. Data on A, B and F is active-high.

Top module: `alu_slice4`

## Requirements
- R1: With `logic_mode_i`=1, F is bitwise per select code: 0000 ~A, 0001 ~(A|B), 0010 ~A&B, 0011 0000, 0100 ~(A&B), 0101 ~B, 0110 A^B, 0111 A&~B, 1000 ~A|B, 1001 ~(A^B), 1010 B, 1011 A&B, 1100 1111, 1101 A|~B, 1110 A|B, 1111 A.
- R2: With `logic_mode_i`=1, F does not depend on `carry_in_n_i`.
- R3: `carry_in_n_i` is active-low: 0 adds one to the arithmetic result, 1 adds nothing.
- R4: With `logic_mode_i`=0, F = (X + Y + c) mod 16, where c = ~`carry_in_n_i`, and per bit X = A | (B & S[0]) | (~B & S[1]) and Y = (A & B & S[3]) | (A & ~B & S[2]).
- R5: Arithmetic codes give these results. 0000 gives A, or A+1 with carry. 0011 without carry gives 1111. 0110 gives A-B-1, or A-B with carry. 1001 gives A+B. 1100 gives A+A. 1111 without carry gives A-1.
- R6: `carry_out_n_o` is 0 exactly when X + Y + c >= 16. This holds in both modes.
- R7: `grp_gen_n_o` is 0 exactly when X + Y >= 16, independent of the carry input.
- R8: `grp_prop_n_o` is 0 exactly when X[i] | Y[i] is 1 for all four bits.
- R9: `all_ones_o` is 1 exactly when F = 1111. This holds in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 4 | Operand A, active-high |
| b_i | input | 4 | Operand B, active-high |
| sel_i | input | 4 | Function select S |
| logic_mode_i | input | 1 | 1 = logic functions, 0 = arithmetic |
| carry_in_n_i | input | 1 | Carry input, active-low |
| f_o | output | 4 | Result F |
| carry_out_n_o | output | 1 | Ripple carry output, active-low |
| grp_gen_n_o | output | 1 | Group carry generate, active-low |
| grp_prop_n_o | output | 1 | Group carry propagate, active-low |
| all_ones_o | output | 1 | High when F is all ones |

## Verification
The embedded assertions are evaluated on every input change. They check four things:
- In arithmetic mode, the result and carry-out from the lookahead chain agree with a plain wide addition of the two operand terms.
- A group generate always forces a carry-out.
- The constant logic codes yield all zeros or all ones.
- The pass/increment arithmetic code yields A or A+1.

Only the bench scenarios can show the following. All sixteen logic functions match their truth tables. The polarity of the carry pins is correct. Logic results stay insensitive to the carry. The group propagate and equality outputs are correct over every combination of select, mode, carry and operands.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;
  localparam int unsigned SEL_W = 4;
  typedef logic [SEL_W-1:0] sel_t;
  localparam sel_t SEL_PASS_A = 4'b0000;
  localparam sel_t SEL_ZEROS  = 4'b0011;
  localparam sel_t SEL_ONES   = 4'b1100;
endpackage

// File: rtl/alu_term_gen.sv
module alu_term_gen #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0]  a_i,
  input  logic [WIDTH-1:0]  b_i,
  input  alu_slice_pkg::sel_t sel_i,
  output logic [WIDTH-1:0]  x_o,
  output logic [WIDTH-1:0]  y_o
);
  // Per-bit operand terms: S[1:0] shape X, S[3:2] shape Y.
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign x_o[i] = a_i[i] | (b_i[i] & sel_i[0]) | (~b_i[i] & sel_i[1]);
    assign y_o[i] = (a_i[i] & b_i[i] & sel_i[3]) | (a_i[i] & ~b_i[i] & sel_i[2]);
  end
endmodule

// File: rtl/alu_lookahead.sv
module alu_lookahead #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             c0_i,
  output logic [WIDTH:0]   carry_o,
  output logic             grp_gen_o,
  output logic             grp_prop_o
);
  logic [WIDTH-1:0] gen;
  logic [WIDTH-1:0] prop;

  assign gen  = x_i & y_i;
  assign prop = x_i | y_i;

  always_comb begin
    logic gacc;
    gacc = 1'b0;
    carry_o[0] = c0_i;
    for (int i = 0; i < WIDTH; i++) begin
      carry_o[i+1] = gen[i] | (prop[i] & carry_o[i]);
      gacc         = gen[i] | (prop[i] & gacc);
    end
    grp_gen_o  = gacc;
    grp_prop_o = &prop;
  end

  always_comb begin
    AST_GEN_FORCES_CARRY: assert (!grp_gen_o || carry_o[WIDTH]) else $error("generate without carry-out"); // R6
    AST_PROP_PASSES_CARRY: assert (!(grp_prop_o && c0_i) || carry_o[WIDTH]) else $error("propagate lost carry"); // R8
  end
endmodule

// File: rtl/alu_result.sv
module alu_result #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic [WIDTH-1:0] carry_i,
  input  logic             logic_mode_i,
  output logic [WIDTH-1:0] f_o,
  output logic             all_ones_o
);
  logic [WIDTH-1:0] half;

  assign half       = x_i ^ y_i;
  assign f_o        = logic_mode_i ? ~half : (half ^ carry_i);
  assign all_ones_o = &f_o;
endmodule

// File: rtl/alu_slice4.sv
module alu_slice4 #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [3:0]       sel_i,
  input  logic             logic_mode_i,
  input  logic             carry_in_n_i,
  output logic [WIDTH-1:0] f_o,
  output logic             carry_out_n_o,
  output logic             grp_gen_n_o,
  output logic             grp_prop_n_o,
  output logic             all_ones_o
);
  import alu_slice_pkg::*;

  logic [WIDTH-1:0] x_term;
  logic [WIDTH-1:0] y_term;
  logic [WIDTH:0]   carry;
  logic             c0;
  logic             grp_gen;
  logic             grp_prop;
  logic [WIDTH:0]   wide_sum;
  logic [WIDTH-1:0] a_plus_c;

  assign c0 = ~carry_in_n_i;

  alu_term_gen #(.WIDTH(WIDTH)) u_terms (
    .a_i   (a_i),
    .b_i   (b_i),
    .sel_i (sel_i),
    .x_o   (x_term),
    .y_o   (y_term)
  );

  alu_lookahead #(.WIDTH(WIDTH)) u_carry (
    .x_i        (x_term),
    .y_i        (y_term),
    .c0_i       (c0),
    .carry_o    (carry),
    .grp_gen_o  (grp_gen),
    .grp_prop_o (grp_prop)
  );

  alu_result #(.WIDTH(WIDTH)) u_result (
    .x_i          (x_term),
    .y_i          (y_term),
    .carry_i      (carry[WIDTH-1:0]),
    .logic_mode_i (logic_mode_i),
    .f_o          (f_o),
    .all_ones_o   (all_ones_o)
  );

  assign carry_out_n_o = ~carry[WIDTH];
  assign grp_gen_n_o   = ~grp_gen;
  assign grp_prop_n_o  = ~grp_prop;

  // Reference quantities for the assertions only.
  assign wide_sum = {1'b0, x_term} + {1'b0, y_term} + {{WIDTH{1'b0}}, c0};
  assign a_plus_c = a_i + {{(WIDTH-1){1'b0}}, c0};

  always_comb begin
    AST_ARITH_MATCHES_ADD: assert (logic_mode_i || ({~carry_out_n_o, f_o} == wide_sum)) else $error("lookahead differs from adder"); // R4
    AST_LOGIC_ZEROS: assert (!(logic_mode_i && sel_i == SEL_ZEROS) || f_o == '0) else $error("zero code not zero"); // R1
    AST_LOGIC_ONES: assert (!(logic_mode_i && sel_i == SEL_ONES) || (f_o == '1 && all_ones_o)) else $error("ones code not ones"); // R9
    AST_ARITH_PASS_A: assert (logic_mode_i || sel_i != SEL_PASS_A || f_o == a_plus_c) else $error("pass code wrong"); // R5
  end
endmodule

// File: tb/test_alu_slice4.sv
module test_alu_slice4;
  logic       clk;
  logic       rst_n;
  logic [3:0] a, b, sel, f;
  logic       mode, cin_n, cout_n, gg_n, gp_n, aeq;
  int         checks = 0;
  int         errors = 0;
  bit         done = 0;

  typedef struct packed {
    logic       mode;
    logic [3:0] f;
    logic       cout_n, gg_n, gp_n, aeq;
  } item_t;
  item_t q[$];

  alu_slice4 i_alu_slice4 (
    .a_i(a), .b_i(b), .sel_i(sel), .logic_mode_i(mode), .carry_in_n_i(cin_n),
    .f_o(f), .carry_out_n_o(cout_n), .grp_gen_n_o(gg_n), .grp_prop_n_o(gp_n),
    .all_ones_o(aeq)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] logic_ref(input logic [3:0] s, input logic [3:0] av, input logic [3:0] bv);
    case (s)
      4'h0: return ~av;        4'h1: return ~(av | bv);
      4'h2: return ~av & bv;   4'h3: return 4'h0;
      4'h4: return ~(av & bv); 4'h5: return ~bv;
      4'h6: return av ^ bv;    4'h7: return av & ~bv;
      4'h8: return ~av | bv;   4'h9: return ~(av ^ bv);
      4'hA: return bv;         4'hB: return av & bv;
      4'hC: return 4'hF;       4'hD: return av | ~bv;
      4'hE: return av | bv;    default: return av;
    endcase
  endfunction

  function automatic item_t model(input logic [3:0] s, input logic [3:0] av, input logic [3:0] bv,
                                  input logic m, input logic cn);
    item_t it;
    logic [3:0] xv, yv;
    logic [4:0] s5, g5;
    xv = av | (bv & {4{s[0]}}) | (~bv & {4{s[1]}});
    yv = (av & bv & {4{s[3]}}) | (av & ~bv & {4{s[2]}});
    s5 = {1'b0, xv} + {1'b0, yv} + {4'b0, ~cn};
    g5 = {1'b0, xv} + {1'b0, yv};
    it.mode   = m;
    it.f      = m ? logic_ref(s, av, bv) : s5[3:0];
    it.cout_n = ~s5[4];
    it.gg_n   = ~g5[4];
    it.gp_n   = ~(&(xv | yv));
    it.aeq    = (it.f == 4'hF);
    return it;
  endfunction

  task automatic drive(input logic [3:0] s, input logic [3:0] av, input logic [3:0] bv,
                       input logic m, input logic cn);
    @(posedge clk);
    sel = s; a = av; b = bv; mode = m; cin_n = cn;
    q.push_back(model(s, av, bv, m, cn));
  endtask

  task automatic direct(input logic [3:0] s, input logic [3:0] av, input logic [3:0] bv,
                        input logic m, input logic cn, input logic [3:0] exp_f, input string tag);
    @(posedge clk);
    sel = s; a = av; b = bv; mode = m; cin_n = cn;
    @(negedge clk);
    chk(f == exp_f, tag, {4'h0, f}, {4'h0, exp_f});
  endtask

  // Monitor: pops one expected item per cycle and compares.
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        chk(f == it.f, it.mode ? "R1/R2" : "R4", {4'h0, f}, {4'h0, it.f});
        chk(cout_n == it.cout_n, "R6", {7'h0, cout_n}, {7'h0, it.cout_n});
        chk(gg_n == it.gg_n, "R7", {7'h0, gg_n}, {7'h0, it.gg_n});
        chk(gp_n == it.gp_n, "R8", {7'h0, gp_n}, {7'h0, it.gp_n});
        chk(aeq == it.aeq, "R9", {7'h0, aeq}, {7'h0, it.aeq});
      end
    end
  end

  initial begin
    logic [3:0] f_c0, f_c1;
    sel = 0; a = 0; b = 0; mode = 0; cin_n = 1; rst_n = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    // Initial state: all-zero inputs, no carry.
    @(negedge clk);
    chk(f == 4'h0 && cout_n && gg_n && gp_n && !aeq, "R4/R9 idle",
        {f, cout_n, gg_n, gp_n, aeq}, 8'h0E);
    // R5 directed arithmetic examples
    direct(4'b0000, 4'hA, 4'h5, 0, 0, 4'hB, "R5 A+1");
    direct(4'b0000, 4'hA, 4'h5, 0, 1, 4'hA, "R5 A");
    direct(4'b0011, 4'hA, 4'h5, 0, 1, 4'hF, "R5 minus one");
    direct(4'b0110, 4'h0, 4'h1, 0, 0, 4'hF, "R5 A-B");
    direct(4'b0110, 4'h7, 4'h2, 0, 1, 4'h4, "R5 A-B-1");
    direct(4'b1001, 4'hE, 4'h3, 0, 1, 4'h1, "R5 A+B");
    chk(cout_n == 1'b0, "R6 wrap carry", {7'h0, cout_n}, 8'h00);
    direct(4'b1100, 4'hF, 4'hF, 0, 1, 4'hE, "R5 A+A");
    direct(4'b1111, 4'h0, 4'h1, 0, 1, 4'hF, "R5 A-1");
    // R3 carry polarity
    direct(4'b1001, 4'h3, 4'h4, 0, 0, 4'h8, "R3 carry adds");
    direct(4'b1001, 4'h3, 4'h4, 0, 1, 4'h7, "R3 no carry");
    // R2 logic result unaffected by carry
    direct(4'b0110, 4'hC, 4'hA, 1, 0, 4'h6, "R2 cin=0");
    f_c0 = f;
    direct(4'b0110, 4'hC, 4'hA, 1, 1, 4'h6, "R2 cin=1");
    f_c1 = f;
    chk(f_c0 == f_c1, "R2 same", {4'h0, f_c1}, {4'h0, f_c0});
    direct(4'b0100, 4'hA, 4'h5, 1, 1, 4'hF, "R1 nand");
    chk(aeq == 1'b1, "R9 logic ones", {7'h0, aeq}, 8'h01);
    // Exhaustive scoreboard sweep
    for (int s = 0; s < 16; s++)
      for (int m = 0; m < 2; m++)
        for (int c = 0; c < 2; c++)
          for (int ai = 0; ai < 16; ai++)
            for (int bi = 0; bi < 16; bi++)
              drive(4'(s), 4'(ai), 4'(bi), 1'(m), 1'(c));
    repeat (3) @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule